// File: doc/BRIEF.md
# Relocatable Interrupt Vector Address Generator

This block sits beside a processor core's fetch logic. It produces two program-word addresses. The first is where execution begins after reset. The second is where the core must jump when it accepts an interrupt. It watches 34 peripheral request lines, applies the per-source enables and the global enable, and picks the winning source.

Both the reset address and the interrupt table can be placed at the bottom of program memory (the application area) or at the start of the boot area near the top of memory. The placement is set by a boot-reset fuse input and a table-select input, and each of the two moves on its own. The size of the boot area is taken from a 2-bit setting.

A legacy-compatibility input hides the upper group of sources. Two lock inputs block interrupts depending on where the table lives and which area the core is executing from. The core raises a take strobe at an instruction boundary. The block answers one cycle later with a registered address, the vector number and a valid pulse.

Top module: `ivg_vector_gen`

## Requirements
- R1: With `boot_rst_n` high (fuse unprogrammed), `reset_vec` is 0x0000. With `boot_rst_n` low, `reset_vec` equals the boot start address. `reset_vec` follows its inputs combinationally.
- R2: The boot start address depends on `boot_size`: 0 gives 0xF000, 1 gives 0xF800, 2 gives 0xFC00 and 3 gives 0xFE00.
- R3: Source k (bit k of `irq_pend`, with k from 0 to 33) is vector number k+2. Its address is the table base plus 2*k. The table base is 0x0002 when `vec_sel` is 0, and the boot start address plus 2 when `vec_sel` is 1.
- R4: When several eligible sources are pending, the one with the lowest vector number wins.
- R5: A source is eligible only when its `irq_pend` bit, its `irq_en` bit and `gie` are all 1.
- R6: When `compat` is 1, vectors 25 to 35 (bits 23 to 33) are never issued, and lower vectors still are.
- R7: When `vec_sel` is 1, `lock_app` is 1 and `in_boot` is 0, no interrupt is issued.
- R8: When `vec_sel` is 0, `lock_boot` is 1 and `in_boot` is 1, no interrupt is issued.
- R9: In each cycle where `core_take` is 1 and an eligible source exists, `vec_valid` is 1 in the following cycle, together with that source's `vec_addr` and `vec_num`. Otherwise `vec_valid` is 0 in the following cycle, and `vec_addr` and `vec_num` hold their values.
- R10: While `rst` is high, `vec_valid`, `vec_addr` and `vec_num` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | 34 | Pending request per source, bit k is vector k+2 |
| irq_en | input | 34 | Per-source enable |
| gie | input | 1 | Global interrupt enable |
| core_take | input | 1 | Core can accept an interrupt this cycle |
| boot_rst_n | input | 1 | Boot-reset fuse, 0 = programmed |
| vec_sel | input | 1 | Interrupt table in boot area when 1 |
| boot_size | input | 2 | Boot area size code |
| compat | input | 1 | Legacy mode, hides vectors 25 to 35 |
| lock_app | input | 1 | Lock blocking interrupts in the application area when the table is in boot |
| lock_boot | input | 1 | Lock blocking interrupts in the boot area when the table is in the application area |
| in_boot | input | 1 | Core currently executes from the boot area |
| reset_vec | output | 16 | Reset word address |
| vec_valid | output | 1 | Interrupt accepted, address valid |
| vec_addr | output | 16 | Interrupt vector word address |
| vec_num | output | 6 | Issued vector number (2 to 35) |

## Verification
The assertions compare each issued vector with the requests, enables, mode and lock inputs of the cycle before. They therefore assume those inputs are steady across the accepting clock edge, with no glitch, and that `boot_size` is a valid 2-bit code. The stimulus changes inputs only on the falling clock edge and raises `core_take` for single cycles, except in one burst. The bench samples the outputs one falling edge later.

// File: rtl/ivg_pkg.sv
package ivg_pkg;

    localparam int ADDR_W         = 16;
    localparam int BSZ_W          = 2;
    localparam int ADDR_SPACE     = 1 << ADDR_W;
    localparam int DEF_N_SRC      = 34;
    localparam int DEF_COMPAT_SRC = 23;
    localparam int DEF_BOOT_WORDS = 4096;
    localparam int FIRST_IRQ_NUM  = 2;

    typedef logic [ADDR_W-1:0] waddr_t;

    typedef struct packed {
        waddr_t reset_addr;
        waddr_t table_base;
    } layout_t;

    // Boot area occupies the top of memory; larger codes halve its size.
    function automatic waddr_t boot_start(input logic [BSZ_W-1:0] sz, input int max_words);
        int words;
        words = max_words >> sz;
        return ADDR_W'(ADDR_SPACE - words);
    endfunction

endpackage

// File: rtl/ivg_layout.sv
module ivg_layout
    import ivg_pkg::*;
#(
    parameter int BOOT_WORDS = DEF_BOOT_WORDS
) (
    input  logic             boot_rst_n,
    input  logic             vec_sel,
    input  logic [BSZ_W-1:0] boot_size,
    output layout_t          layout
);
    waddr_t boot_base;

    always_comb begin
        boot_base = boot_start(boot_size, BOOT_WORDS);
        layout.reset_addr = boot_rst_n ? '0 : boot_base;
        layout.table_base = (vec_sel ? boot_base : '0) + ADDR_W'(FIRST_IRQ_NUM);
    end
endmodule

// File: rtl/ivg_gate.sv
module ivg_gate (
    input  logic vec_sel,
    input  logic lock_app,
    input  logic lock_boot,
    input  logic in_boot,
    output logic blocked
);
    logic app_blk, boot_blk;

    always_comb begin
        app_blk  = vec_sel  & lock_app  & ~in_boot;
        boot_blk = ~vec_sel & lock_boot &  in_boot;
        blocked  = app_blk | boot_blk;
    end
endmodule

// File: rtl/ivg_eligible.sv
module ivg_eligible #(
    parameter int N_SRC      = 34,
    parameter int COMPAT_SRC = 23
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] en,
    input  logic             gie,
    input  logic             compat,
    input  logic             blocked,
    output logic [N_SRC-1:0] elig
);
    logic open_gate;
    assign open_gate = gie & ~blocked;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (g >= COMPAT_SRC) begin : g_ext
            assign elig[g] = pend[g] & en[g] & open_gate & ~compat;
        end else begin : g_base
            assign elig[g] = pend[g] & en[g] & open_gate;
        end
    end
endmodule

// File: rtl/ivg_priority.sv
module ivg_priority #(
    parameter int N_SRC = 34,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] elig,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // Scan downwards so the lowest set bit is the last one written.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ivg_vector_gen.sv
module ivg_vector_gen
    import ivg_pkg::*;
#(
    parameter int N_SRC      = DEF_N_SRC,
    parameter int COMPAT_SRC = DEF_COMPAT_SRC,
    parameter int BOOT_WORDS = DEF_BOOT_WORDS,
    localparam int NUM_W     = $clog2(N_SRC + FIRST_IRQ_NUM),
    localparam int IDX_W     = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_pend,
    input  logic [N_SRC-1:0]  irq_en,
    input  logic              gie,
    input  logic              core_take,
    input  logic              boot_rst_n,
    input  logic              vec_sel,
    input  logic [BSZ_W-1:0]  boot_size,
    input  logic              compat,
    input  logic              lock_app,
    input  logic              lock_boot,
    input  logic              in_boot,
    output logic [ADDR_W-1:0] reset_vec,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [NUM_W-1:0]  vec_num
);
    layout_t          layout;
    logic             blocked;
    logic [N_SRC-1:0] elig;
    logic             hit;
    logic [IDX_W-1:0] idx;
    waddr_t           next_addr;
    logic [NUM_W-1:0] next_num;

    ivg_layout #(.BOOT_WORDS(BOOT_WORDS)) u_layout (
        .boot_rst_n (boot_rst_n),
        .vec_sel    (vec_sel),
        .boot_size  (boot_size),
        .layout     (layout)
    );

    ivg_gate u_gate (
        .vec_sel   (vec_sel),
        .lock_app  (lock_app),
        .lock_boot (lock_boot),
        .in_boot   (in_boot),
        .blocked   (blocked)
    );

    ivg_eligible #(.N_SRC(N_SRC), .COMPAT_SRC(COMPAT_SRC)) u_elig (
        .pend    (irq_pend),
        .en      (irq_en),
        .gie     (gie),
        .compat  (compat),
        .blocked (blocked),
        .elig    (elig)
    );

    ivg_priority #(.N_SRC(N_SRC)) u_prio (
        .elig (elig),
        .hit  (hit),
        .idx  (idx)
    );

    assign reset_vec = layout.reset_addr;

    always_comb begin
        next_addr = layout.table_base + ADDR_W'({idx, 1'b0});
        next_num  = NUM_W'(idx) + NUM_W'(FIRST_IRQ_NUM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_addr  <= '0;
            vec_num   <= '0;
        end else begin
            vec_valid <= core_take & hit;
            if (core_take && hit) begin
                vec_addr <= next_addr;
                vec_num  <= next_num;
            end
        end
    end
endmodule

// File: rtl/ivg_vector_gen_chk.sv
module ivg_vector_gen_chk
    import ivg_pkg::*;
#(
    parameter int N_SRC = DEF_N_SRC,
    parameter int NUM_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [N_SRC-1:0]  irq_pend,
    input logic [N_SRC-1:0]  irq_en,
    input logic              gie,
    input logic              core_take,
    input logic              boot_rst_n,
    input logic              vec_sel,
    input logic              compat,
    input logic              lock_app,
    input logic              lock_boot,
    input logic              in_boot,
    input logic [ADDR_W-1:0] reset_vec,
    input logic              vec_valid,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [NUM_W-1:0]  vec_num
);
    logic [N_SRC-1:0] pend_q, en_q;
    logic gie_q, take_q, sel_q, compat_q, lapp_q, lboot_q, inb_q;
    logic lower_pending, own_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0; en_q <= '0; gie_q <= 1'b0; take_q <= 1'b0;
            sel_q <= 1'b0; compat_q <= 1'b0; lapp_q <= 1'b0; lboot_q <= 1'b0; inb_q <= 1'b0;
        end else begin
            pend_q <= irq_pend; en_q <= irq_en; gie_q <= gie; take_q <= core_take;
            sel_q <= vec_sel; compat_q <= compat; lapp_q <= lock_app;
            lboot_q <= lock_boot; inb_q <= in_boot;
        end
    end

    always_comb begin
        lower_pending = 1'b0;
        own_req       = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (i + FIRST_IRQ_NUM < int'(vec_num) && pend_q[i] && en_q[i]) lower_pending = 1'b1;
            if (i + FIRST_IRQ_NUM == int'(vec_num) && pend_q[i] && en_q[i]) own_req = 1'b1;
        end
    end

    a_r1_app_reset: assert property (@(posedge clk) disable iff (rst)
        boot_rst_n |-> reset_vec == '0);
    a_r2_boot_reset: assert property (@(posedge clk) disable iff (rst)
        !boot_rst_n |-> (reset_vec[ADDR_W-1:12] == 4'hF && reset_vec[8:0] == '0));
    a_r3_app_table: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !sel_q) |-> (vec_addr < ADDR_W'(16'h0046) && !vec_addr[0]));
    a_r3_boot_table: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && sel_q) |-> (vec_addr[ADDR_W-1:12] == 4'hF && !vec_addr[0]));
    a_r4_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> !lower_pending);
    a_r5_enabled_req: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (gie_q && own_req));
    a_r6_compat_hidden: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && compat_q) |-> vec_num < NUM_W'(25));
    a_r7_app_lock: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> !(sel_q && lapp_q && !inb_q));
    a_r8_boot_lock: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> !(!sel_q && lboot_q && inb_q));
    a_r9_needs_take: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> take_q);
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> ($stable(vec_addr) && $stable(vec_num)));
endmodule

bind ivg_vector_gen ivg_vector_gen_chk #(.N_SRC(N_SRC), .NUM_W(NUM_W)) u_chk (.*);

// File: tb/test_ivg_vector_gen.sv
module test_ivg_vector_gen;
    localparam int N = 34;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] irq_pend = '0, irq_en = '1;
    logic gie = 1'b1, core_take = 1'b0, boot_rst_n = 1'b1, vec_sel = 1'b0;
    logic [1:0] boot_size = 2'd0;
    logic compat = 1'b0, lock_app = 1'b0, lock_boot = 1'b0, in_boot = 1'b0;
    logic [15:0] reset_vec, vec_addr;
    logic vec_valid;
    logic [5:0] vec_num;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ivg_vector_gen i_ivg_vector_gen (
        .clk(clk), .rst(rst), .irq_pend(irq_pend), .irq_en(irq_en), .gie(gie),
        .core_take(core_take), .boot_rst_n(boot_rst_n), .vec_sel(vec_sel),
        .boot_size(boot_size), .compat(compat), .lock_app(lock_app),
        .lock_boot(lock_boot), .in_boot(in_boot), .reset_vec(reset_vec),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .vec_num(vec_num)
    );

    function automatic int bstart(input int sz);
        return 32'h10000 - (4096 >> sz);
    endfunction

    function automatic int tbase(input bit sel, input int sz);
        return sel ? bstart(sz) + 2 : 2;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        irq_pend = '0; irq_en = '1; gie = 1'b1; core_take = 1'b0;
        boot_rst_n = 1'b1; vec_sel = 1'b0; boot_size = 2'd0; compat = 1'b0;
        lock_app = 1'b0; lock_boot = 1'b0; in_boot = 1'b0;
    endtask

    // Raise take for one cycle; outputs are sampled at the next falling edge.
    task automatic accept();
        @(negedge clk);
        core_take = 1'b1;
        @(negedge clk);
        core_take = 1'b0;
    endtask

    task automatic expect_vec(input string req, input int num, input bit sel, input int sz);
        accept();
        check(req, int'(vec_valid), 1);
        check(req, int'(vec_num), num);
        check(req, int'(vec_addr), tbase(sel, sz) + 2 * (num - 2));
    endtask

    task automatic expect_none(input string req);
        accept();
        check(req, int'(vec_valid), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        irq_pend = '1;
        core_take = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 valid", int'(vec_valid), 0);
        check("R10 addr", int'(vec_addr), 0);
        check("R10 num", int'(vec_num), 0);
        core_take = 1'b0;
        rst = 1'b0;
        idle();
    endtask

    task automatic t_reset_vec();
        for (int sz = 0; sz < 4; sz++) begin
            @(negedge clk);
            boot_size = 2'(sz);
            boot_rst_n = 1'b1;
            #1 check("R1 unprogrammed", int'(reset_vec), 0);
            boot_rst_n = 1'b0;
            #1 check("R1 R2 programmed", int'(reset_vec), bstart(sz));
        end
        check("R2 8K start", bstart(0), 32'hF000);
        idle();
    endtask

    task automatic t_table();
        int srcs[3] = '{0, 5, 33};
        for (int s = 0; s < 2; s++) begin
            for (int sz = 0; sz < 4; sz += 3) begin
                foreach (srcs[j]) begin
                    idle();
                    vec_sel = 1'(s);
                    boot_size = 2'(sz);
                    irq_pend = '0;
                    irq_pend[srcs[j]] = 1'b1;
                    expect_vec("R3 table", srcs[j] + 2, 1'(s), sz);
                end
            end
        end
        idle();
    endtask

    task automatic t_priority();
        irq_pend = '0; irq_pend[3] = 1'b1; irq_pend[7] = 1'b1; irq_pend[20] = 1'b1;
        expect_vec("R4 mixed", 5, 1'b0, 0);
        irq_pend = '1;
        expect_vec("R4 all", 2, 1'b0, 0);
        irq_pend = '0; irq_pend[33] = 1'b1; irq_pend[32] = 1'b1;
        expect_vec("R4 top pair", 34, 1'b0, 0);
        idle();
    endtask

    task automatic t_enable();
        irq_pend = '0; irq_pend[4] = 1'b1; irq_pend[9] = 1'b1;
        irq_en[4] = 1'b0;
        expect_vec("R5 masked skipped", 11, 1'b0, 0);
        irq_en = '1; gie = 1'b0;
        expect_none("R5 gie off");
        gie = 1'b1; irq_en = '0;
        expect_none("R5 all disabled");
        idle();
    endtask

    task automatic t_compat();
        compat = 1'b1;
        irq_pend = '0; irq_pend[23] = 1'b1;
        expect_none("R6 vector 25 hidden");
        irq_pend[22] = 1'b1;
        expect_vec("R6 vector 24 kept", 24, 1'b0, 0);
        irq_pend = '0; irq_pend[33] = 1'b1;
        expect_none("R6 vector 35 hidden");
        compat = 1'b0; irq_pend = '0; irq_pend[23] = 1'b1;
        expect_vec("R6 off shows 25", 25, 1'b0, 0);
        idle();
    endtask

    task automatic t_lock_app();
        irq_pend = '0; irq_pend[1] = 1'b1;
        vec_sel = 1'b1; lock_app = 1'b1; in_boot = 1'b0;
        expect_none("R7 blocked in app");
        in_boot = 1'b1;
        expect_vec("R7 open in boot", 3, 1'b1, 0);
        vec_sel = 1'b0; in_boot = 1'b0;
        expect_vec("R7 table in app", 3, 1'b0, 0);
        idle();
    endtask

    task automatic t_lock_boot();
        irq_pend = '0; irq_pend[2] = 1'b1;
        vec_sel = 1'b0; lock_boot = 1'b1; in_boot = 1'b1;
        expect_none("R8 blocked in boot");
        in_boot = 1'b0;
        expect_vec("R8 open in app", 4, 1'b0, 0);
        vec_sel = 1'b1; in_boot = 1'b1;
        expect_vec("R8 table in boot", 4, 1'b1, 0);
        idle();
    endtask

    task automatic t_timing();
        irq_pend = '0; irq_pend[6] = 1'b1;
        @(negedge clk);
        check("R9 no take no valid", int'(vec_valid), 0);
        core_take = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9 burst valid", int'(vec_valid), 1);
            check("R9 burst num", int'(vec_num), 8);
        end
        core_take = 1'b0;
        irq_pend = '0;
        @(negedge clk);
        check("R9 drops", int'(vec_valid), 0);
        check("R9 addr held", int'(vec_addr), 2 + 2 * 6);
        expect_none("R9 take without request");
        check("R9 num held", int'(vec_num), 8);
        idle();
    endtask

    initial begin
        t_reset();
        t_reset_vec();
        t_table();
        t_priority();
        t_enable();
        t_compat();
        t_lock_app();
        t_lock_boot();
        t_timing();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule